// File: doc/BRIEF.md
# Two-Dimensional Victim Selector

This block picks which cache block to evict when a lookup misses in a macro-block whose blocks form a grid of rows and columns. Two policies share the choice: a pseudo-random source names the row, and a true least-recently-used order kept separately for every row names the column within that row. The lookup supplies a match map with one bit per block. A bit is set when that block's partial CAM tag equals the partial tag of the missing address. Only blocks that keep every column's CAM tag unique may be chosen.

The user pulses `miss_req` together with the match map for that miss. The chosen row and column appear on the cycle after the pulse, qualified by `vict_valid`. Every hit and every fill is reported on the update port, which refreshes the recency order of the accessed row. The recency state and the random source live inside the block. Tag storage and data movement are outside it.

Top module: `tdvs_victim_sel`

## Requirements
- R1: `vict_valid` is high in exactly the cycle after each cycle with `miss_req` high. `vict_row` and `vict_col` hold their value in the cycles between misses.
- R2: Reset is synchronous and active high. After reset the random register holds 16'hACE1 and every row ranks its columns in index order: column 0 is the most recent and column COLS-1 is the least recent.
- R3: The random register is a 16-bit right-shifting Galois LFSR with feedback mask 16'hB400. It advances once on each clock edge where `miss_req` is high, and at no other time. The start row of a miss is the low log2(ROWS) bits of the register value held before that advance.
- R4: If no bit of the match map is set, the victim row is the start row and the victim column is the least recent column of that row.
- R5: If every column has at least one set bit, the victim row is the first row at or after the start row, wrapping from ROWS-1 to 0, that holds at least one set bit. The victim column is the least recent of that row's matching columns.
- R6: If some columns, but not all of them, have a set bit, the victim row is the start row. The victim column is the least recent column of that row among the columns that have no set bit in any row.
- R7: An update makes the accessed column the most recent in its row. Columns that were more recent than it move one step older, and all other columns keep their rank.
- R8: When a miss and an update arrive in the same cycle, the victim is chosen from the recency state as it stood before that update.
- R9: Match map bit r*COLS+c belongs to row r, column c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_req | input | 1 | Miss strobe, one cycle per miss |
| match_map | input | ROWS*COLS | Partial-tag match per block, bit r*COLS+c |
| upd_valid | input | 1 | A hit or fill touched a block |
| upd_row | input | log2(ROWS) | Row of the touched block |
| upd_col | input | log2(COLS) | Column of the touched block |
| vict_valid | output | 1 | Victim outputs carry a new choice |
| vict_row | output | log2(ROWS) | Chosen victim row |
| vict_col | output | log2(COLS) | Chosen victim column |

## Verification
The checker assumes that the match map never holds two set bits in one column, since the lookup keeps CAM tags unique per column. It also assumes that a miss with an all-zero map follows a single update with no update in the same cycle before it applies the most-recent rule. The bench builds every match map by choosing at most one row per column. It interleaves misses of all three match classes with runs of updates and with same-cycle update and miss pairs. A reference model derived from the requirements predicts the random sequence and the rank tables.

// File: rtl/tdvs_pkg.sv
package tdvs_pkg;

    localparam int              LFSR_W    = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [1:0] {
        MC_NONE = 2'd0,
        MC_ALL  = 2'd1,
        MC_SOME = 2'd2
    } match_case_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

endpackage

// File: rtl/tdvs_lfsr.sv
module tdvs_lfsr
    import tdvs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    output logic [LFSR_W-1:0] state_o
);
    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)        state_q <= LFSR_SEED;
        else if (adv_i) state_q <= lfsr_step(state_q);
    end

    assign state_o = state_q;
endmodule

// File: rtl/tdvs_lru_rows.sv
module tdvs_lru_rows #(
    parameter int ROWS = 16,
    parameter int COLS = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               upd_valid,
    input  logic [$clog2(ROWS)-1:0]            upd_row,
    input  logic [$clog2(COLS)-1:0]            upd_col,
    output logic [ROWS*COLS*$clog2(COLS)-1:0]  ranks_o
);
    localparam int ROW_W    = $clog2(ROWS);
    localparam int RANK_W   = $clog2(COLS);
    localparam int ROW_BITS = COLS * RANK_W;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [ROW_BITS-1:0] row_q;
        logic [RANK_W-1:0]   hit_rank;

        assign hit_rank = row_q[int'(upd_col)*RANK_W +: RANK_W];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int c = 0; c < COLS; c++)
                    row_q[c*RANK_W +: RANK_W] <= RANK_W'(c);
            end else if (upd_valid && upd_row == ROW_W'(r)) begin
                for (int c = 0; c < COLS; c++) begin
                    if (upd_col == RANK_W'(c))
                        row_q[c*RANK_W +: RANK_W] <= '0;
                    else if (row_q[c*RANK_W +: RANK_W] < hit_rank)
                        row_q[c*RANK_W +: RANK_W] <= row_q[c*RANK_W +: RANK_W] + 1'b1;
                end
            end
        end

        assign ranks_o[r*ROW_BITS +: ROW_BITS] = row_q;
    end
endmodule

// File: rtl/tdvs_row_pick.sv
module tdvs_row_pick #(
    parameter int ROWS = 16
) (
    input  logic [ROWS-1:0]         elig_i,
    input  logic [$clog2(ROWS)-1:0] start_i,
    output logic [$clog2(ROWS)-1:0] row_o
);
    localparam int ROW_W = $clog2(ROWS);

    logic [ROW_W-1:0] idx;
    logic             found;

    always_comb begin
        row_o = start_i;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < ROWS; k++) begin
            idx = start_i + ROW_W'(k);
            if (!found && elig_i[idx]) begin
                row_o = idx;
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdvs_col_pick.sv
module tdvs_col_pick #(
    parameter int COLS = 8
) (
    input  logic [COLS-1:0]               mask_i,
    input  logic [COLS*$clog2(COLS)-1:0]  ranks_i,
    output logic [$clog2(COLS)-1:0]       col_o
);
    localparam int RANK_W = $clog2(COLS);

    logic [RANK_W-1:0] best;
    logic              found;

    always_comb begin
        col_o = '0;
        best  = '0;
        found = 1'b0;
        for (int c = 0; c < COLS; c++) begin
            if (mask_i[c] && (!found || ranks_i[c*RANK_W +: RANK_W] > best)) begin
                best  = ranks_i[c*RANK_W +: RANK_W];
                col_o = RANK_W'(c);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdvs_victim_sel.sv
module tdvs_victim_sel
    import tdvs_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    miss_req,
    input  logic [ROWS*COLS-1:0]    match_map,
    input  logic                    upd_valid,
    input  logic [$clog2(ROWS)-1:0] upd_row,
    input  logic [$clog2(COLS)-1:0] upd_col,
    output logic                    vict_valid,
    output logic [$clog2(ROWS)-1:0] vict_row,
    output logic [$clog2(COLS)-1:0] vict_col
);
    localparam int ROW_W    = $clog2(ROWS);
    localparam int RANK_W   = $clog2(COLS);
    localparam int ROW_BITS = COLS * RANK_W;

    logic [LFSR_W-1:0]        lfsr;
    logic [ROWS*ROW_BITS-1:0] ranks;
    logic [COLS-1:0]          col_hit;
    logic [ROWS-1:0]          row_hit;
    logic [ROWS-1:0]          elig;
    match_case_e              mcase;
    logic [ROW_W-1:0]         pick_row;
    logic [COLS-1:0]          row_match;
    logic [COLS-1:0]          col_mask;
    logic [ROW_BITS-1:0]      row_ranks;
    logic [RANK_W-1:0]        pick_col;

    tdvs_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (miss_req),
        .state_o (lfsr)
    );

    tdvs_lru_rows #(.ROWS(ROWS), .COLS(COLS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .upd_row   (upd_row),
        .upd_col   (upd_col),
        .ranks_o   (ranks)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_rowhit
        assign row_hit[r] = |match_map[r*COLS +: COLS];
    end

    always_comb begin
        col_hit = '0;
        for (int r = 0; r < ROWS; r++)
            col_hit = col_hit | match_map[r*COLS +: COLS];
    end

    always_comb begin
        if (col_hit == '0)  mcase = MC_NONE;
        else if (&col_hit)  mcase = MC_ALL;
        else                mcase = MC_SOME;
    end

    assign elig = (mcase == MC_ALL) ? row_hit : '1;

    tdvs_row_pick #(.ROWS(ROWS)) u_row (
        .elig_i  (elig),
        .start_i (lfsr[ROW_W-1:0]),
        .row_o   (pick_row)
    );

    assign row_match = match_map[int'(pick_row)*COLS +: COLS];
    assign row_ranks = ranks[int'(pick_row)*ROW_BITS +: ROW_BITS];

    always_comb begin
        case (mcase)
            MC_ALL:  col_mask = row_match;
            MC_SOME: col_mask = ~col_hit;
            default: col_mask = '1;
        endcase
    end

    tdvs_col_pick #(.COLS(COLS)) u_col (
        .mask_i  (col_mask),
        .ranks_i (row_ranks),
        .col_o   (pick_col)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vict_valid <= 1'b0;
            vict_row   <= '0;
            vict_col   <= '0;
        end else begin
            vict_valid <= miss_req;
            if (miss_req) begin
                vict_row <= pick_row;
                vict_col <= pick_col;
            end
        end
    end
endmodule

// File: rtl/tdvs_victim_sel_chk.sv
module tdvs_victim_sel_chk #(
    parameter int ROWS = 16,
    parameter int COLS = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    miss_req,
    input logic [ROWS*COLS-1:0]    match_map,
    input logic                    upd_valid,
    input logic [$clog2(ROWS)-1:0] upd_row,
    input logic [$clog2(COLS)-1:0] upd_col,
    input logic                    vict_valid,
    input logic [$clog2(ROWS)-1:0] vict_row,
    input logic [$clog2(COLS)-1:0] vict_col
);
    logic                    miss_q;
    logic [ROWS*COLS-1:0]    map_q;
    logic [COLS-1:0]         hit_now;
    logic [COLS-1:0]         colhit_q;
    logic                    prev_upd;
    logic [$clog2(ROWS)-1:0] prev_row;
    logic [$clog2(COLS)-1:0] prev_col;
    logic                    mru_chk_q;
    logic [$clog2(ROWS)-1:0] mru_row_q;
    logic [$clog2(COLS)-1:0] mru_col_q;
    logic                    vict_matched;

    always_comb begin
        hit_now = '0;
        for (int r = 0; r < ROWS; r++)
            hit_now = hit_now | match_map[r*COLS +: COLS];
    end

    assign vict_matched = map_q[int'(vict_row)*COLS + int'(vict_col)];

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_q    <= 1'b0;
            map_q     <= '0;
            colhit_q  <= '0;
            prev_upd  <= 1'b0;
            prev_row  <= '0;
            prev_col  <= '0;
            mru_chk_q <= 1'b0;
            mru_row_q <= '0;
            mru_col_q <= '0;
        end else begin
            miss_q    <= miss_req;
            map_q     <= match_map;
            colhit_q  <= hit_now;
            prev_upd  <= upd_valid;
            prev_row  <= upd_row;
            prev_col  <= upd_col;
            mru_chk_q <= miss_req && match_map == '0 && !upd_valid && prev_upd;
            mru_row_q <= prev_row;
            mru_col_q <= prev_col;
        end
    end

    // R1
    valid_after_miss_chk: assert property (@(posedge clk) disable iff (rst)
        vict_valid == miss_q);

    // R5
    full_match_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (vict_valid && (&colhit_q)) |-> vict_matched);

    // R6
    partial_match_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (vict_valid && colhit_q != '0 && !(&colhit_q)) |-> !colhit_q[vict_col]);

    // R7
    touched_not_evicted_chk: assert property (@(posedge clk) disable iff (rst)
        (vict_valid && mru_chk_q && vict_row == mru_row_q) |-> vict_col != mru_col_q);
endmodule

bind tdvs_victim_sel tdvs_victim_sel_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .miss_req   (miss_req),
    .match_map  (match_map),
    .upd_valid  (upd_valid),
    .upd_row    (upd_row),
    .upd_col    (upd_col),
    .vict_valid (vict_valid),
    .vict_row   (vict_row),
    .vict_col   (vict_col)
);

// File: tb/tdvs_victim_sel_bench.sv
module tdvs_victim_sel_bench;
    localparam int PERIOD = 10;
    localparam int ROWS   = 16;
    localparam int COLS   = 8;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 miss_req = 1'b0;
    logic [ROWS*COLS-1:0] match_map = '0;
    logic                 upd_valid = 1'b0;
    logic [ROW_W-1:0]     upd_row = '0;
    logic [COL_W-1:0]     upd_col = '0;
    logic                 vict_valid;
    logic [ROW_W-1:0]     vict_row;
    logic [COL_W-1:0]     vict_col;

    tdvs_victim_sel #(.ROWS(ROWS), .COLS(COLS)) u_tdvs_victim_sel (
        .clk(clk), .rst(rst), .miss_req(miss_req), .match_map(match_map),
        .upd_valid(upd_valid), .upd_row(upd_row), .upd_col(upd_col),
        .vict_valid(vict_valid), .vict_row(vict_row), .vict_col(vict_col)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // reference model
    logic [15:0] m_lfsr;
    int          m_rank [ROWS][COLS];
    int          exp_row, exp_col;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lfsr = 16'hACE1;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) m_rank[r][c] = c;
    endtask

    task automatic model_touch(input int r, input int c);
        int old;
        old = m_rank[r][c];
        for (int k = 0; k < COLS; k++) begin
            if (k == c) m_rank[r][k] = 0;
            else if (m_rank[r][k] < old) m_rank[r][k] = m_rank[r][k] + 1;
        end
    endtask

    function automatic logic [15:0] model_step(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    // predicts victim per R4/R5/R6 using R9 bit mapping; returns class 0 none, 1 all, 2 some
    function automatic int model_victim(input logic [ROWS*COLS-1:0] map);
        logic [COLS-1:0] ch;
        logic [COLS-1:0] msk;
        int start, cls, best;
        ch = '0;
        for (int r = 0; r < ROWS; r++) ch = ch | map[r*COLS +: COLS];
        start = int'(m_lfsr[ROW_W-1:0]);
        exp_row = start;
        if (ch == '0) begin
            cls = 0; msk = '1;
        end else if (&ch) begin
            cls = 1;
            for (int k = ROWS-1; k >= 0; k--)
                if (map[((start + k) % ROWS)*COLS +: COLS] != '0) exp_row = (start + k) % ROWS;
            msk = map[exp_row*COLS +: COLS];
        end else begin
            cls = 2; msk = ~ch;
        end
        best = -1;
        for (int c = 0; c < COLS; c++)
            if (msk[c] && m_rank[exp_row][c] > best) begin
                best = m_rank[exp_row][c];
                exp_col = c;
            end
        return cls;
    endfunction

    // one clock: optional miss and/or update, then check the victim when a miss was issued
    task automatic step(input bit miss, input logic [ROWS*COLS-1:0] map,
                        input bit upd, input int ur, input int uc, input string tag);
        int cls;
        @(negedge clk);
        miss_req  = miss;
        match_map = map;
        upd_valid = upd;
        upd_row   = ROW_W'(ur);
        upd_col   = COL_W'(uc);
        cls = miss ? model_victim(map) : 0;
        @(negedge clk);
        miss_req  = 1'b0;
        upd_valid = 1'b0;
        match_map = '0;
        if (miss) begin
            chk(vict_valid === 1'b1, {"R1 ", tag}, int'(vict_valid), 1);
            case (cls)
                0: begin
                    chk(int'(vict_row) == exp_row, {"R4 row ", tag}, int'(vict_row), exp_row);
                    chk(int'(vict_col) == exp_col, {"R4 col ", tag}, int'(vict_col), exp_col);
                end
                1: begin
                    chk(int'(vict_row) == exp_row, {"R5 row ", tag}, int'(vict_row), exp_row);
                    chk(int'(vict_col) == exp_col, {"R5 col ", tag}, int'(vict_col), exp_col);
                end
                default: begin
                    chk(int'(vict_row) == exp_row, {"R6 row ", tag}, int'(vict_row), exp_row);
                    chk(int'(vict_col) == exp_col, {"R6 col ", tag}, int'(vict_col), exp_col);
                end
            endcase
            m_lfsr = model_step(m_lfsr);   // R3
        end
        if (upd) model_touch(ur, uc);      // R7, after victim: R8
    endtask

    function automatic logic [ROWS*COLS-1:0] make_map(input int cls);
        logic [ROWS*COLS-1:0] m;
        logic [COLS-1:0] use_col;
        m = '0;
        if (cls == 1) use_col = '1;
        else if (cls == 2) begin
            use_col = COLS'($urandom);
            while (use_col == '0 || &use_col) use_col = COLS'($urandom);
        end else use_col = '0;
        for (int c = 0; c < COLS; c++)
            if (use_col[c]) m[($urandom % ROWS)*COLS + c] = 1'b1;
        return m;
    endfunction

    initial begin
        logic [ROWS*COLS-1:0] m;
        logic [ROW_W-1:0] hold_r;
        logic [COL_W-1:0] hold_c;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state of outputs
        chk(vict_valid === 1'b0, "R2 valid after reset", int'(vict_valid), 0);
        // R2 R4: seed low bits give row 1; column COLS-1 is least recent
        step(1'b1, '0, 1'b0, 0, 0, "first miss");
        chk(int'(vict_row) == 1, "R2 seed row", int'(vict_row), 1);
        chk(int'(vict_col) == COLS-1, "R2 initial LRU col", int'(vict_col), COLS-1);
        // R1: outputs hold, valid drops
        hold_r = vict_row; hold_c = vict_col;
        @(negedge clk);
        chk(vict_valid === 1'b0, "R1 valid drop", int'(vict_valid), 0);
        chk(vict_row == hold_r && vict_col == hold_c, "R1 hold", int'(vict_col), int'(hold_c));

        // R7 R9 directed: row 5 only, all columns, touched 7 down to 0 -> col 7 oldest
        for (int c = COLS-1; c >= 0; c--) step(1'b0, '0, 1'b1, 5, c, "touch");
        m = '0;
        for (int c = 0; c < COLS; c++) m[5*COLS + c] = 1'b1;
        step(1'b1, m, 1'b0, 0, 0, "R7 dir a");
        chk(int'(vict_row) == 5 && int'(vict_col) == COLS-1, "R7 R9 oldest", int'(vict_col), COLS-1);
        step(1'b0, '0, 1'b1, 5, COLS-1, "touch");
        step(1'b1, m, 1'b0, 0, 0, "R7 dir b");
        chk(int'(vict_col) == COLS-2, "R7 aged", int'(vict_col), COLS-2);
        // R8: same-cycle update of the would-be victim
        step(1'b1, m, 1'b1, 5, COLS-2, "R8 same cycle");
        chk(int'(vict_col) == COLS-2, "R8 pre-update state", int'(vict_col), COLS-2);
        step(1'b1, m, 1'b0, 0, 0, "R8 after");

        // near-exhaustive mix of classes, update runs, and R3 LFSR sequencing
        for (int it = 0; it < 1500; it++) begin
            int nu;
            nu = $urandom % 4;
            for (int u = 0; u < nu; u++)
                step(1'b0, '0, 1'b1, $urandom % ROWS, $urandom % COLS, "upd");
            if (it % 7 == 0)
                step(1'b1, make_map(it % 3), 1'b1, $urandom % ROWS, $urandom % COLS, "R8 mix");
            else
                step(1'b1, make_map(it % 3), 1'b0, 0, 0, "R3 sweep");
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule